// File: doc/BRIEF.md
# Nibble-Command Register Access Port

This block decodes a stream of command bytes from a host link and turns it into accesses to an 8-bit internal register file. Every command byte carries an opcode in its upper nibble and a 4-bit payload in its lower nibble. The host builds a register address and the write data one nibble at a time. A data-high command commits a full byte to the core through a single-cycle write strobe.

Read commands sample the addressed register and place one byte on a response stream. That byte is held until the host side takes it. A read variant steps the address up by one after it samples, so a run of such reads walks consecutive registers. A six-read run is how a host fetches two 24-bit counters that sit in adjacent registers, least significant byte first.

The command input and the response output each use a valid/ready handshake. The core side is a plain address, write strobe, write data and read data port. The read data is expected to follow the address within the same cycle.

Top module: `nib_cmd_port`

## Requirements
- R1: After reset the address is 0x00, the held low data nibble is 0x0, no response is pending, and cmd_ready is 1.
- R2: An accepted command with opcode 0x0 replaces address bits [3:0] with the payload. An accepted command with opcode 0x1 replaces address bits [7:4]. The other half of the address is kept.
- R3: An accepted command with opcode 0x2 stores its payload as the held low data nibble. An accepted command with opcode 0x3 drives reg_we high in its acceptance cycle, with reg_wdata = {payload, held low nibble} and reg_addr equal to the current address.
- R4: Write commands leave the address unchanged, so consecutive writes go to the same register. The held low nibble survives a write and is reused until a new opcode 0x2 arrives.
- R5: An accepted command with opcode 0x4 samples reg_rdata in its acceptance cycle. The sampled byte appears on rsp_data with rsp_valid high in the following cycle, and the address is left unchanged.
- R6: Opcode 0x5 behaves like 0x4 and also raises the address by one after sampling. The address wraps from 0xFF to 0x00.
- R7: While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data stay unchanged. cmd_ready is low whenever a response is pending.
- R8: Accepted commands with opcodes 0x6 to 0xF produce no write, no response and no address change.
- R9: Six consecutive opcode 0x5 reads starting at address A return the registers A to A+5 in that order, and they leave the address at A+6.
- R10: A command byte that is not accepted, because cmd_valid or cmd_ready is low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Opcode [7:4], payload [3:0] |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Response byte taken |
| rsp_data | output | 8 | Sampled register byte |
| reg_addr | output | 8 | Current register address |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
Two events can fall in the same cycle. One is the host taking a pending response. The other is a new command waiting at the input. The bench provokes this by issuing a read and holding rsp_ready low for several cycles while it presents an address-stepping read. It then raises rsp_ready and checks three things: the waiting command is not taken in the drain cycle, it is taken exactly one cycle later, and it yields exactly one new response and exactly one address step. This shows that the command is neither lost nor taken twice.

// File: rtl/nib_port_pkg.sv
package nib_port_pkg;
  localparam logic [3:0] OP_ADDR_LO   = 4'h0;
  localparam logic [3:0] OP_ADDR_HI   = 4'h1;
  localparam logic [3:0] OP_DATA_LO   = 4'h2;
  localparam logic [3:0] OP_DATA_HI   = 4'h3;
  localparam logic [3:0] OP_READ      = 4'h4;
  localparam logic [3:0] OP_READ_STEP = 4'h5;

  typedef struct packed {
    logic ld_alo;
    logic ld_ahi;
    logic ld_dlo;
    logic wr;
    logic rd;
    logic step;
  } ctl_t;
endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
  import nib_port_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             fire,
  input  logic [NIB_W-1:0] opcode,
  output ctl_t             ctl
);
  always_comb begin
    ctl = '0;
    if (fire) begin
      ctl.ld_alo = (opcode == NIB_W'(OP_ADDR_LO));
      ctl.ld_ahi = (opcode == NIB_W'(OP_ADDR_HI));
      ctl.ld_dlo = (opcode == NIB_W'(OP_DATA_LO));
      ctl.wr     = (opcode == NIB_W'(OP_DATA_HI));
      ctl.rd     = (opcode == NIB_W'(OP_READ)) || (opcode == NIB_W'(OP_READ_STEP));
      ctl.step   = (opcode == NIB_W'(OP_READ_STEP));
    end
  end
endmodule

// File: rtl/nib_addr_reg.sv
module nib_addr_reg #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic               step,
  input  logic [NIB_W-1:0]   nib,
  output logic [2*NIB_W-1:0] addr
);
  localparam int AW = 2 * NIB_W;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_ld;
  logic [AW-1:0] addr_d;
  logic [1:0]    ld_half;

  assign ld_half = {ld_hi, ld_lo};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign addr_ld[h*NIB_W +: NIB_W] = ld_half[h] ? nib : addr_q[h*NIB_W +: NIB_W];
  end

  always_comb begin
    addr_d = addr_ld;
    if (step) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      addr_q <= '0;
    else if (ld_lo || ld_hi || step) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/nib_rsp_slot.sv
module nib_rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] dout
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (pop)  valid_d = 1'b0;
    if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= din;
  end

  assign valid = valid_q;
  assign dout  = data_q;
endmodule

// File: rtl/nib_cmd_port.sv
module nib_cmd_port
  import nib_port_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2*NIB_W-1:0] cmd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2*NIB_W-1:0] rsp_data,
  output logic [2*NIB_W-1:0] reg_addr,
  output logic               reg_we,
  output logic [2*NIB_W-1:0] reg_wdata,
  input  logic [2*NIB_W-1:0] reg_rdata
);
  localparam int BW = 2 * NIB_W;

  logic             fire;
  logic [NIB_W-1:0] opcode;
  logic [NIB_W-1:0] payload;
  logic [NIB_W-1:0] dlo_q;
  ctl_t             ctl;

  assign opcode    = cmd_data[BW-1 -: NIB_W];
  assign payload   = cmd_data[NIB_W-1:0];
  assign cmd_ready = !rsp_valid;
  assign fire      = cmd_valid && cmd_ready;

  nib_cmd_decode #(.NIB_W(NIB_W)) u_dec (
    .fire   (fire),
    .opcode (opcode),
    .ctl    (ctl)
  );

  nib_addr_reg #(.NIB_W(NIB_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (ctl.ld_alo),
    .ld_hi (ctl.ld_ahi),
    .step  (ctl.step),
    .nib   (payload),
    .addr  (reg_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dlo_q <= '0;
    else if (ctl.ld_dlo) dlo_q <= payload;
  end

  assign reg_we    = ctl.wr;
  assign reg_wdata = {payload, dlo_q};

  nib_rsp_slot #(.W(BW)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctl.rd),
    .din   (reg_rdata),
    .pop   (rsp_ready),
    .valid (rsp_valid),
    .dout  (rsp_data)
  );
endmodule

// File: rtl/nib_cmd_port_chk.sv
module nib_cmd_port_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2*NIB_W-1:0] cmd_data,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [2*NIB_W-1:0] rsp_data,
  input logic [2*NIB_W-1:0] reg_addr,
  input logic               reg_we,
  input logic [2*NIB_W-1:0] reg_rdata
);
  localparam int BW = 2 * NIB_W;

  logic             acc;
  logic [NIB_W-1:0] op;

  assign acc = cmd_valid && cmd_ready;
  assign op  = cmd_data[BW-1 -: NIB_W];

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (acc && op == NIB_W'(3)));

  assert_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == NIB_W'(4)) |=>
      (rsp_valid && reg_addr == $past(reg_addr) && rsp_data == $past(reg_rdata)));

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == NIB_W'(5)) |=>
      (rsp_valid && reg_addr == BW'($past(reg_addr) + 1'b1)));

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op > NIB_W'(5)) |=> (!rsp_valid && $stable(reg_addr)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(reg_addr));

  assert_wr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == NIB_W'(2) || op == NIB_W'(3))) |=> $stable(reg_addr));
endmodule

bind nib_cmd_port nib_cmd_port_chk #(.NIB_W(NIB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata)
);

// File: tb/sim_nib_cmd_port.sv
module sim_nib_cmd_port;
  localparam int CLK_P = 10;
  localparam int NV    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic [7:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  logic [7:0] mem [256];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic       we_s;
  logic [7:0] wa_s, wd_s;

  always #(CLK_P/2) clk = ~clk;

  nib_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] mval(input int a);
    return 8'(a * 7 + 3);
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = mval(i);
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  // kind: 0 = state command, 1 = write, 2 = read
  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] kind;
    logic [7:0] eaddr;
    logic [7:0] edata;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'h0A, 2'd0, 8'h0A, 8'h00},
    '{8'h13, 2'd0, 8'h3A, 8'h00},
    '{8'h25, 2'd0, 8'h3A, 8'h00},
    '{8'h3C, 2'd1, 8'h3A, 8'hC5},
    '{8'h27, 2'd0, 8'h3A, 8'h00},
    '{8'h31, 2'd1, 8'h3A, 8'h17},
    '{8'h40, 2'd2, 8'h3A, 8'h17},
    '{8'h38, 2'd1, 8'h3A, 8'h87},
    '{8'h50, 2'd2, 8'h3B, 8'h87},
    '{8'h40, 2'd2, 8'h3B, 8'hA0},
    '{8'h9F, 2'd0, 8'h3B, 8'h00},
    '{8'h6E, 2'd0, 8'h3B, 8'h00},
    '{8'h0F, 2'd0, 8'h3F, 8'h00},
    '{8'h1F, 2'd0, 8'hFF, 8'h00},
    '{8'h50, 2'd2, 8'h00, 8'hFC},
    '{8'h40, 2'd2, 8'h00, 8'h03}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    we_s = reg_we;
    wa_s = reg_addr;
    wd_s = reg_wdata;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 8'h00;
  endtask

  task automatic pop_rsp(input logic [7:0] exp, input string req);
    chk(rsp_valid === 1'b1, req, 16'(rsp_valid), 16'd1);
    chk(cmd_ready === 1'b0, "R7", 16'(cmd_ready), 16'd0);
    chk(rsp_data === exp, req, 16'(rsp_data), 16'(exp));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0, "R7", 16'(rsp_valid), 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready === 1'b1, "R1", 16'(cmd_ready), 16'd1);
    chk(rsp_valid === 1'b0, "R1", 16'(rsp_valid), 16'd0);
    chk(reg_addr === 8'h00, "R1", 16'(reg_addr), 16'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      do_cmd(VEC[v].cmd);
      case (VEC[v].kind)
        2'd1: begin
          chk(we_s === 1'b1, "R3", 16'(we_s), 16'd1);
          chk(wa_s === VEC[v].eaddr, "R4", 16'(wa_s), 16'(VEC[v].eaddr));
          chk(wd_s === VEC[v].edata, "R3", 16'(wd_s), 16'(VEC[v].edata));
        end
        2'd2: begin
          chk(we_s === 1'b0, "R5", 16'(we_s), 16'd0);
          pop_rsp(VEC[v].edata, "R5");
        end
        default: begin
          chk(we_s === 1'b0, "R8", 16'(we_s), 16'd0);
          chk(rsp_valid === 1'b0, "R8", 16'(rsp_valid), 16'd0);
        end
      endcase
      chk(reg_addr === VEC[v].eaddr, "R2/R6", 16'(reg_addr), 16'(VEC[v].eaddr));
    end

    // R10: command byte presented without valid
    cmd_data = 8'h3F;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(reg_we === 1'b0, "R10", 16'(reg_we), 16'd0);
    end
    chk(reg_addr === 8'h00, "R10", 16'(reg_addr), 16'h00);
    cmd_data = 8'h00;

    // R9: six stepping reads from 0x10
    do_cmd(8'h00);
    do_cmd(8'h11);
    for (int k = 0; k < 6; k++) begin
      do_cmd(8'h50);
      pop_rsp(mval(16 + k), "R9");
    end
    chk(reg_addr === 8'h16, "R9", 16'(reg_addr), 16'h16);

    // R7: response held while a stepping read waits at the input
    do_cmd(8'h40);
    cmd_valid = 1'b1;
    cmd_data  = 8'h50;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_data === mval(22), "R7", 16'(rsp_data), 16'(mval(22)));
      chk(cmd_ready === 1'b0, "R7", 16'(cmd_ready), 16'd0);
      chk(reg_addr === 8'h16, "R7", 16'(reg_addr), 16'h16);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0 && cmd_ready === 1'b1, "R7", 16'(rsp_valid), 16'd0);
    chk(reg_addr === 8'h16, "R7", 16'(reg_addr), 16'h16);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 8'h00;
    chk(reg_addr === 8'h17, "R6", 16'(reg_addr), 16'h17);
    pop_rsp(mval(22), "R6");
    chk(reg_addr === 8'h17, "R6", 16'(reg_addr), 16'h17);

    // R1: reset mid-stream clears address and held nibble
    do_cmd(8'h2B);
    do_cmd(8'h04);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(reg_addr === 8'h00, "R1", 16'(reg_addr), 16'h00);
    rst_n = 1'b1;
    do_cmd(8'h39);
    chk(we_s === 1'b1 && wa_s === 8'h00, "R1", 16'(wa_s), 16'h00);
    chk(wd_s === 8'h90, "R1", 16'(wd_s), 16'h90);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule